// File: doc/BRIEF.md
# Dynamic On-Die Termination Selector for DDR3 Devices

This block sits inside a cycle-accurate DDR3 memory device model and chooses the data-bus termination on every clock. Outside of writes, the termination turns on and off with the sampled ODT pin, delayed by the write latency minus two clocks, and it uses the nominal code held in mode register 1. When dynamic termination is enabled in mode register 2, each registered write-class command swaps the active code to the write code for the length of the burst. The swap happens with fixed latencies and needs no mode-register command.

The return to the nominal code depends on the burst. A chopped burst of four returns sooner than a burst of eight. A write that arrives before the return is due extends the write window, so the write termination stays continuous across back-to-back writes. While the DLL is disabled, dynamic termination is forced off and only the nominal behaviour applies. The cycle in which the active source changes is flagged as having an undefined value.

Top module: `dyn_odt_ctrl`

## Requirements
- R1: After reset, `term_en` is 0, `term_code` is 0, `term_sel_wr` is 0 and `term_valid` is 1.
- R2: Let L = `wl` − 2, with `wl` ≥ 5. The `odt_pin` value sampled at clock edge k controls termination on/off from edge k+L onward. Outside a write window the active code is the nominal code {`mr1`[9], `mr1`[6], `mr1`[2]}.
- R3: `term_en` is 1 only when the delayed pin is 1 and the selected code is nonzero. Whenever `term_en` is 0, both `term_code` and `term_sel_wr` are 0.
- R4: A write counts as dynamic only if, at the edge where `cmd_write` is sampled, `mr2`[10:9] is nonzero and `dll_off` is 0. Any other write leaves the outputs on the nominal code.
- R5: A dynamic write sampled at edge k sets `term_sel_wr` to 1 and `term_code` to {0, `mr2`[10:9]} from edge k+L, provided the delayed pin is 1.
- R6: With `cmd_bc4` = 1 at the write edge, the write code is held for 4 clocks and the nominal code returns at edge k+L+4. With `cmd_bc4` = 0 it is held for 6 clocks and returns at edge k+L+6.
- R7: A dynamic write that arrives while an earlier window is still running restarts the return timing from the new write, with no nominal gap in between.
- R8: `term_valid` is 0 for exactly the clock after each edge at which `term_sel_wr` changes value. At all other times it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_write | input | 1 | Registered decode of any write-class command |
| cmd_bc4 | input | 1 | Burst of this write is chopped to four (fixed or on the fly) |
| odt_pin | input | 1 | Sampled termination-control pin |
| mr1 | input | 16 | Mode register 1 contents (nominal code in bits 9, 6, 2) |
| mr2 | input | 16 | Mode register 2 contents (write code in bits 10:9) |
| wl | input | 4 | Write latency in clocks, at least 5 |
| dll_off | input | 1 | DLL-disable mode active |
| term_en | output | 1 | Termination enabled |
| term_code | output | 3 | Active termination code, 0 when disabled |
| term_sel_wr | output | 1 | Active code is the write code |
| term_valid | output | 1 | 0 during the source-transition clock |

## Verification
The bench goes after the exact edge on which the write code starts and ends, for both burst lengths. A design that counts an extra register, or swaps the chop lengths, fails on the boundary cycle. Back-to-back BL8 writes two clocks apart catch a design that returns to nominal after the first burst instead of restarting the window. Writes with the DLL disabled, or with the write code field zero, must leave the nominal code untouched. A pin held low during a write must keep the code at zero, and a nominal code of zero must keep termination off. The transition flag is checked on both edges of each window, so a flag that lags one cycle or never clears is caught.

// File: rtl/dodt_pkg.sv
package dodt_pkg;
   localparam int CODE_W = 3;

   function automatic logic [CODE_W-1:0] nom_code(input logic [15:0] mr);
      return {mr[9], mr[6], mr[2]};
   endfunction

   function automatic logic [CODE_W-1:0] wr_code(input logic [15:0] mr);
      return {1'b0, mr[10:9]};
   endfunction
endpackage

// File: rtl/dodt_delay_line.sv
module dodt_delay_line #(
   parameter int W     = 3,
   parameter int DEPTH = 14,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     d,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     q
);
   logic [W-1:0] stg [DEPTH+1];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[g] <= '0;
         else        stg[g] <= stg[g-1];
      end
   end

   always_comb begin
      q = '0;
      for (int i = 0; i <= DEPTH; i++)
         if (32'(sel) == i) q = stg[i];
   end

   if (DEPTH < 1) begin : g_bad_depth
      $error("dodt_delay_line: DEPTH must be at least 1");
   end
endmodule

// File: rtl/dodt_wr_window.sv
module dodt_wr_window #(
   parameter int SHORT_LEN = 4,
   parameter int LONG_LEN  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic short_burst,
   output logic active
);
   localparam int CNT_W = $clog2(LONG_LEN + 1);
   localparam logic [CNT_W-1:0] SHORT_RELOAD = CNT_W'(SHORT_LEN - 1);
   localparam logic [CNT_W-1:0] LONG_RELOAD  = CNT_W'(LONG_LEN - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (start)           cnt <= short_burst ? SHORT_RELOAD : LONG_RELOAD;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign active = start | (cnt != '0);

   if (SHORT_LEN < 1 || LONG_LEN < SHORT_LEN) begin : g_bad_len
      $error("dodt_wr_window: need 1 <= SHORT_LEN <= LONG_LEN");
   end

   // R7: a start reloads the window, otherwise it counts down by one
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == SHORT_RELOAD || cnt == LONG_RELOAD));
   // R6: without a start, a running window shrinks by one each clock
   a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dyn_odt_ctrl.sv
module dyn_odt_ctrl #(
   parameter int WL_W    = 4,
   parameter int MR_W    = 16,
   parameter int BC4_LEN = 4,
   parameter int BL8_LEN = 6,
   parameter int MIN_WL  = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_write,
   input  logic                       cmd_bc4,
   input  logic                       odt_pin,
   input  logic [MR_W-1:0]            mr1,
   input  logic [MR_W-1:0]            mr2,
   input  logic [WL_W-1:0]            wl,
   input  logic                       dll_off,
   output logic                       term_en,
   output logic [dodt_pkg::CODE_W-1:0] term_code,
   output logic                       term_sel_wr,
   output logic                       term_valid
);
   import dodt_pkg::*;

   localparam int DEPTH = (1 << WL_W) - 2;

   if (MR_W < 11) begin : g_bad_mr
      $error("dyn_odt_ctrl: MR_W must cover bit 10");
   end
   if (MIN_WL < 3) begin : g_bad_wl
      $error("dyn_odt_ctrl: MIN_WL must be at least 3");
   end

   logic [WL_W-1:0]   lat;
   logic              dyn_en;
   logic [2:0]        line_in, line_out;
   logic              odt_d, wr_start, wr_chop, wr_act;
   logic [CODE_W-1:0] code_sel;
   logic              sel_q;

   assign lat    = wl - WL_W'(2);
   assign dyn_en = (mr2[10] | mr2[9]) & ~dll_off;
   assign line_in = {odt_pin, cmd_write & dyn_en, cmd_write & dyn_en & cmd_bc4};

   dodt_delay_line #(.W(3), .DEPTH(DEPTH), .SEL_W(WL_W)) u_line (
      .clk(clk), .rst_n(rst_n), .d(line_in), .sel(lat), .q(line_out)
   );

   assign odt_d    = line_out[2];
   assign wr_start = line_out[1];
   assign wr_chop  = line_out[0];

   dodt_wr_window #(.SHORT_LEN(BC4_LEN), .LONG_LEN(BL8_LEN)) u_win (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .short_burst(wr_chop),
      .active(wr_act)
   );

   assign code_sel    = wr_act ? wr_code(mr2[15:0]) : nom_code(mr1[15:0]);
   assign term_en     = odt_d & (code_sel != '0);
   assign term_code   = term_en ? code_sel : '0;
   assign term_sel_wr = term_en & wr_act;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= term_sel_wr;
   end

   assign term_valid = (term_sel_wr == sel_q);

   // R2: latency assumption on the write-latency input
   a_r2_wl_min: assert property (@(posedge clk) disable iff (!rst_n)
      wl >= WL_W'(MIN_WL));
   // R3: a disabled termination reports no code and no write selection
   a_r3_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !term_en |-> (term_code == '0 && !term_sel_wr));
   // R8: entering the write code is flagged as a transition
   a_r8_rise_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(term_sel_wr) |-> !term_valid);
   // R8: leaving the write code is flagged as a transition
   a_r8_fall_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(term_sel_wr) |-> !term_valid);
endmodule

// File: tb/tb_dyn_odt_ctrl.sv
module tb_dyn_odt_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_write = 1'b0, cmd_bc4 = 1'b0, odt_pin = 1'b0, dll_off = 1'b0;
   logic [15:0] mr1 = 16'h0204;   // nominal code 3'b101
   logic [15:0] mr2 = 16'h0400;   // write code 3'b010
   logic [3:0]  wl = 4'd7;
   logic term_en, term_sel_wr, term_valid;
   logic [2:0] term_code;

   int n_chk = 0, n_bad = 0;
   localparam int L = 5;
   localparam logic [2:0] NOM = 3'b101, WRC = 3'b010;

   always #10 clk = ~clk;

   dyn_odt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .cmd_bc4(cmd_bc4),
      .odt_pin(odt_pin), .mr1(mr1), .mr2(mr2), .wl(wl), .dll_off(dll_off),
      .term_en(term_en), .term_code(term_code), .term_sel_wr(term_sel_wr),
      .term_valid(term_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One or two writes (second at offset gap, 0 = none); checks every cycle.
   task automatic run_writes(input bit bc4, input int gap, input bit dyn, input string req);
      int len, last;
      bit es, prev;
      len  = bc4 ? 4 : 6;
      last = L + gap + len;
      prev = 1'b0;
      cmd_bc4 = bc4;
      cmd_write = 1'b1;
      for (int m = 1; m <= last + 4; m++) begin
         @(negedge clk);
         es = dyn && (m >= L + 1) && (m <= last);
         chk(term_sel_wr == es, req, term_sel_wr, es);
         chk(term_code == (es ? WRC : NOM), req, term_code, es ? WRC : NOM);
         chk(term_valid == (es == prev), {req, " R8"}, term_valid, es == prev);
         prev = es;
         cmd_write = (gap > 0 && m == gap);
      end
      cmd_write = 1'b0;
      idle(4);
   endtask

   task automatic t_reset;
      chk(term_en == 1'b0 && term_code == 3'd0, "R1", term_code, 0);
      chk(term_sel_wr == 1'b0 && term_valid == 1'b1, "R1", term_valid, 1);
   endtask

   task automatic t_pin_latency;
      odt_pin = 1'b1;
      for (int m = 1; m <= L + 2; m++) begin
         @(negedge clk);
         chk(term_en == (m >= L + 1), "R2 on", term_en, m >= L + 1);
      end
      chk(term_code == NOM, "R2 nominal code", term_code, NOM);
      odt_pin = 1'b0;
      for (int m = 1; m <= L + 2; m++) begin
         @(negedge clk);
         chk(term_en == (m < L + 1), "R2 off", term_en, m < L + 1);
      end
      chk(term_code == 3'd0, "R3 code zero when off", term_code, 0);
   endtask

   task automatic t_zero_nominal;
      mr1 = 16'h0000;
      odt_pin = 1'b1;
      idle(L + 3);
      chk(term_en == 1'b0 && term_code == 3'd0, "R3 zero nominal", term_en, 0);
      mr1 = 16'h0204;
      @(negedge clk);
      chk(term_en == 1'b1 && term_code == NOM, "R3 restore", term_code, NOM);
   endtask

   task automatic t_pin_low_write;
      odt_pin = 1'b0;
      idle(L + 3);
      cmd_bc4 = 1'b0;
      cmd_write = 1'b1;
      for (int m = 1; m <= L + 8; m++) begin
         @(negedge clk);
         cmd_write = 1'b0;
         chk(!term_en && term_code == 3'd0 && !term_sel_wr, "R3 pin low write",
             term_code, 0);
      end
      odt_pin = 1'b1;
      idle(L + 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pin_latency();
      t_zero_nominal();
      idle(2);
      run_writes(1'b1, 0, 1'b1, "R5 R6 BC4");
      run_writes(1'b0, 0, 1'b1, "R5 R6 BL8");
      run_writes(1'b0, 2, 1'b1, "R7 back-to-back");
      run_writes(1'b1, 3, 1'b1, "R7 BC4 restart");
      dll_off = 1'b1;
      run_writes(1'b0, 0, 1'b0, "R4 dll off");
      dll_off = 1'b0;
      mr2 = 16'h0000;
      run_writes(1'b0, 0, 1'b0, "R4 write code zero");
      mr2 = 16'h0400;
      t_pin_low_write();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule